// File: doc/BRIEF.md
# Multi-Address SMBus Slave Address Matcher

This block sits behind the bit-level engine of an SMBus/I2C slave. It decides whether the address byte seen after a START belongs to it. The received address is compared with a programmable own address and with three fixed SMBus reserved addresses: Alert Response, Default and Host. Each of the four comparisons has its own enable. The block returns one registered ACK/NAK decision per address phase. Per-source match flags are set and stay set until software clears them. The direction of the transfer is latched from the R/W bit.

When stretching on a match is enabled, an accepted address raises a clock-hold request. The request stays up until software has cleared every match flag. The bit engine reports START and STOP strobes and a flag that says a byte is partly shifted. A START or STOP that arrives while a byte is in flight is a bus error. It shuts off matching until a well-placed START arrives.

The address byte arrives on a valid/ready stream. A byte is taken on a cycle where `addr_valid` and `addr_ready` are both high. `addr_ready` goes low while the clock-hold request is up, and the producer must keep the byte and `addr_valid` steady until it is taken. The response is a one-cycle pulse and cannot be back-pressured.

Top module: `smb_addr_matcher`

## Requirements
- R1: The own address (`addr_byte[7:1]` equal to `own_addr`) produces a match, reported on `match_flags[0]`, only while `src_en[0]` is 1.
- R2: The Alert Response address 7'b0001100 matches only while `src_en[1]` is 1, and is reported on `match_flags[1]`.
- R3: The Default address 7'b1100001 matches only while `src_en[2]` is 1, and is reported on `match_flags[2]`.
- R4: The Host address 7'b0001000 matches only while `src_en[3]` is 1, and is reported on `match_flags[3]`.
- R5: A byte taken while the address phase is open gives `resp_valid` high for exactly the next cycle. `resp_ack` is 1 in that cycle if at least one enabled comparison matched, and 0 otherwise. A NAK changes no match flag.
- R6: Match flags are sticky. Bit i is cleared by `clr_match[i]`, and a set in the same cycle wins over the clear. All enabled comparisons that match set their flags together.
- R7: On an ACK, `xmit_mode` takes the R/W bit `addr_byte[0]` (1 = slave transmits) from the next cycle, and holds it until the next ACK.
- R8: If `stretch_en` is 1 on an ACK, `hold_scl` is high from the next cycle. It stays high until the cycle after every match flag has been cleared.
- R9: A `start_pulse` or `stop_pulse` while `mid_byte` is 1 sets the sticky `bus_err` on the next cycle. `clr_berr` clears it, and a set in the same cycle wins over the clear.
- R10: The address phase opens only on `start_pulse` with `mid_byte` 0. It closes when a byte is taken, on a STOP, or on a bus error. A byte taken while the phase is closed produces no response and changes no flag.
- R11: `addr_ready` equals the inverse of `hold_scl`. A byte offered while the hold is up is not taken and does not close the address phase.
- R12: During and straight after reset, all flags, `bus_err`, `hold_scl`, `resp_valid`, `resp_ack` and `xmit_mode` are 0, `addr_ready` is 1, and the address phase is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address byte valid |
| addr_ready | output | 1 | Address byte can be taken |
| addr_byte | input | 8 | Address in [7:1], R/W in [0] |
| start_pulse | input | 1 | START seen on the bus |
| stop_pulse | input | 1 | STOP seen on the bus |
| mid_byte | input | 1 | A byte is partly shifted |
| own_addr | input | 7 | Programmable own address |
| src_en | input | 4 | Enables: own, alert, default, host |
| stretch_en | input | 1 | Hold the clock after a match |
| clr_match | input | 4 | Per-flag clear strobes |
| clr_berr | input | 1 | Bus-error clear strobe |
| resp_valid | output | 1 | Decision pulse |
| resp_ack | output | 1 | 1 = ACK, 0 = NAK |
| xmit_mode | output | 1 | Latched direction, 1 = slave transmits |
| match_flags | output | 4 | Sticky per-source match flags |
| hold_scl | output | 1 | Clock-hold request |
| bus_err | output | 1 | Sticky bus-error flag |

## Verification
A wrong phase-open bit shows up at the ports within one cycle of the next offered byte: a response pulse appears or goes missing. A corrupted flag or hold register shows up on `match_flags`, `hold_scl` or `addr_ready` in the very cycle it goes wrong. The bench's model predicts every output on every cycle. Any divergence is therefore caught in the cycle it first becomes visible, not at the end of a scenario.

// File: rtl/smb_match_pkg.sv
package smb_match_pkg;
  localparam int ADDR_W = 7;
  localparam int NRSV   = 3;
  localparam int NSRC   = NRSV + 1;

  // Source index order: 0 own, 1 alert response, 2 default, 3 host
  localparam int SRC_OWN = 0;

  function automatic logic [ADDR_W-1:0] rsv_addr(input int idx);
    case (idx)
      0:       rsv_addr = 7'b0001100;
      1:       rsv_addr = 7'b1100001;
      default: rsv_addr = 7'b0001000;
    endcase
  endfunction
endpackage

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp
  import smb_match_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = NSRC
) (
  input  logic [AW-1:0] rx_addr,
  input  logic [AW-1:0] own_addr,
  input  logic [NS-1:0] src_en,
  output logic [NS-1:0] hit
);
  for (genvar i = 0; i < NS; i++) begin : g_src
    if (i == SRC_OWN) begin : g_own
      assign hit[i] = src_en[i] && (rx_addr == own_addr);
    end else begin : g_rsv
      localparam logic [AW-1:0] REF = rsv_addr(i - 1);
      assign hit[i] = src_en[i] && (rx_addr == REF);
    end
  end
endmodule

// File: rtl/smb_flag_bank.sv
module smb_flag_bank #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_vec,
  input  logic [NS-1:0] clr_vec,
  output logic [NS-1:0] flags,
  output logic [NS-1:0] flags_nxt
);
  for (genvar i = 0; i < NS; i++) begin : g_flag
    always_comb begin
      if (set_vec[i])      flags_nxt[i] = 1'b1;
      else if (clr_vec[i]) flags_nxt[i] = 1'b0;
      else                 flags_nxt[i] = flags[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flags_nxt[i];
    end
  end
endmodule

// File: rtl/smb_bus_watch.sv
module smb_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic stop_pulse,
  input  logic mid_byte,
  input  logic byte_taken,
  input  logic clr_berr,
  output logic phase_open,
  output logic bus_err
);
  logic misplaced, good_start;

  assign misplaced  = (start_pulse || stop_pulse) && mid_byte;
  assign good_start = start_pulse && !mid_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_open <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      if (good_start)                                 phase_open <= 1'b1;
      else if (misplaced || stop_pulse || byte_taken) phase_open <= 1'b0;

      if (misplaced)     bus_err <= 1'b1;
      else if (clr_berr) bus_err <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_addr_matcher.sv
module smb_addr_matcher
  import smb_match_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_valid,
  output logic            addr_ready,
  input  logic [AW:0]     addr_byte,
  input  logic            start_pulse,
  input  logic            stop_pulse,
  input  logic            mid_byte,
  input  logic [AW-1:0]   own_addr,
  input  logic [NSRC-1:0] src_en,
  input  logic            stretch_en,
  input  logic [NSRC-1:0] clr_match,
  input  logic            clr_berr,
  output logic            resp_valid,
  output logic            resp_ack,
  output logic            xmit_mode,
  output logic [NSRC-1:0] match_flags,
  output logic            hold_scl,
  output logic            bus_err
);
  logic [NSRC-1:0] hit, set_vec, flags_nxt;
  logic taken, fire, any_hit, phase_open;

  assign addr_ready = !hold_scl;
  assign taken      = addr_valid && addr_ready;
  assign fire       = taken && phase_open;
  assign any_hit    = |hit;
  assign set_vec    = (fire && any_hit) ? hit : '0;

  smb_addr_cmp #(.AW(AW), .NS(NSRC)) u_cmp (
    .rx_addr (addr_byte[AW:1]),
    .own_addr(own_addr),
    .src_en  (src_en),
    .hit     (hit)
  );

  smb_flag_bank #(.NS(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_match),
    .flags    (match_flags),
    .flags_nxt(flags_nxt)
  );

  smb_bus_watch u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .mid_byte   (mid_byte),
    .byte_taken (taken),
    .clr_berr   (clr_berr),
    .phase_open (phase_open),
    .bus_err    (bus_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      xmit_mode  <= 1'b0;
      hold_scl   <= 1'b0;
    end else begin
      resp_valid <= fire;
      resp_ack   <= fire && any_hit;
      if (fire && any_hit) xmit_mode <= addr_byte[0];
      if (fire && any_hit && stretch_en) hold_scl <= 1'b1;
      else if (flags_nxt == '0)          hold_scl <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_addr_matcher_chk.sv
module smb_addr_matcher_chk
  import smb_match_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            addr_valid,
  input logic            addr_ready,
  input logic [AW:0]     addr_byte,
  input logic            start_pulse,
  input logic            stop_pulse,
  input logic            mid_byte,
  input logic [AW-1:0]   own_addr,
  input logic [NSRC-1:0] src_en,
  input logic [NSRC-1:0] clr_match,
  input logic            resp_valid,
  input logic            resp_ack,
  input logic            xmit_mode,
  input logic [NSRC-1:0] match_flags,
  input logic            hold_scl,
  input logic            bus_err
);
  p_own_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flags[0]) |-> $past(src_en[0] && addr_byte[AW:1] == own_addr));
  p_alert_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flags[1]) |-> $past(src_en[1]));
  p_dflt_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flags[2]) |-> $past(src_en[2]));
  p_host_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flags[3]) |-> $past(src_en[3]));
  p_nak_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ack) |-> match_flags == ($past(match_flags) & ~$past(clr_match)));
  p_ack_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ack) |-> match_flags != '0);
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && resp_ack) |-> $stable(xmit_mode));
  p_hold_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_scl |-> match_flags != '0);
  p_berr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past((start_pulse || stop_pulse) && mid_byte));
  p_resp_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(addr_valid && addr_ready));
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ready != hold_scl);
endmodule

bind smb_addr_matcher smb_addr_matcher_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr_byte(addr_byte), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .mid_byte(mid_byte), .own_addr(own_addr), .src_en(src_en),
  .clr_match(clr_match), .resp_valid(resp_valid), .resp_ack(resp_ack),
  .xmit_mode(xmit_mode), .match_flags(match_flags), .hold_scl(hold_scl),
  .bus_err(bus_err)
);

// File: tb/tb_smb_addr_matcher.sv
module tb_smb_addr_matcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_valid = 1'b0, start_pulse = 1'b0, stop_pulse = 1'b0, mid_byte = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic [6:0] own_addr = 7'h00;
  logic [3:0] src_en = 4'h0, clr_match = 4'h0;
  logic stretch_en = 1'b0, clr_berr = 1'b0;
  logic addr_ready, resp_valid, resp_ack, xmit_mode, hold_scl, bus_err;
  logic [3:0] match_flags;

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_open, m_rv, m_ack, m_dir, m_hold, m_berr;
  bit [3:0] m_flags;

  always #5 clk = ~clk;

  smb_addr_matcher dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_byte(addr_byte), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .mid_byte(mid_byte), .own_addr(own_addr), .src_en(src_en),
    .stretch_en(stretch_en), .clr_match(clr_match), .clr_berr(clr_berr),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .xmit_mode(xmit_mode),
    .match_flags(match_flags), .hold_scl(hold_scl), .bus_err(bus_err)
  );

  always @(posedge clk) begin
    bit acc, err, rv, ack;
    bit [3:0] hit, fn;
    if (!rst_n) begin
      m_open <= 0; m_rv <= 0; m_ack <= 0; m_dir <= 0; m_hold <= 0; m_berr <= 0; m_flags <= 0;
    end else begin
      acc = addr_valid && !m_hold;
      hit[0] = src_en[0] && addr_byte[7:1] == own_addr;
      hit[1] = src_en[1] && addr_byte[7:1] == 7'b0001100;
      hit[2] = src_en[2] && addr_byte[7:1] == 7'b1100001;
      hit[3] = src_en[3] && addr_byte[7:1] == 7'b0001000;
      rv  = acc && m_open;
      ack = rv && (hit != 0);
      fn  = m_flags & ~clr_match;
      if (ack) fn = fn | hit;
      err = (start_pulse || stop_pulse) && mid_byte;
      m_rv <= rv; m_ack <= ack; m_flags <= fn;
      if (ack) m_dir <= addr_byte[0];
      if (ack && stretch_en) m_hold <= 1;
      else if (fn == 0) m_hold <= 0;
      if (err) m_berr <= 1; else if (clr_berr) m_berr <= 0;
      if (start_pulse && !mid_byte) m_open <= 1;
      else if (err || stop_pulse || acc) m_open <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (!done) begin
      vectors++;
      if (!rst_n) chk("R12 ready in reset", addr_ready, 1);
      chk("R1 own flag",       match_flags[0], m_flags[0]);
      chk("R2 alert flag",     match_flags[1], m_flags[1]);
      chk("R3 default flag",   match_flags[2], m_flags[2]);
      chk("R4 host flag",      match_flags[3], m_flags[3]);
      chk("R6 flag vector",    match_flags, m_flags);
      chk("R10 resp_valid",    resp_valid, m_rv);
      chk("R5 resp_ack",       resp_ack, m_ack);
      chk("R7 xmit_mode",      xmit_mode, m_dir);
      chk("R8 hold_scl",       hold_scl, m_hold);
      chk("R9 bus_err",        bus_err, m_berr);
      chk("R11 addr_ready",    addr_ready, !m_hold);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input bit mid = 0);
    start_pulse = 1; mid_byte = mid; tick(); start_pulse = 0; mid_byte = 0;
  endtask

  task automatic do_stop(input bit mid = 0);
    stop_pulse = 1; mid_byte = mid; tick(); stop_pulse = 0; mid_byte = 0;
  endtask

  task automatic send(input bit [6:0] a, input bit rw);
    addr_byte = {a, rw}; addr_valid = 1; tick(); addr_valid = 0; tick();
  endtask

  task automatic clear(input bit [3:0] c);
    clr_match = c; tick(); clr_match = 0; tick();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    own_addr = 7'h2A; src_en = 4'b0001;
    do_start(); send(7'h2A, 0);                       // R1 ack, write
    send(7'h2A, 1);                                   // R10 no start: ignored
    do_start(); send(7'h0C, 1);                       // R2 disabled: NAK
    src_en = 4'b1111;
    do_start(); send(7'h0C, 1);                       // R2 match, R7 transmitter
    own_addr = 7'h61;
    do_start(); send(7'h61, 0);                       // R3 + R1 together
    src_en = 4'b1011;
    do_start(); send(7'h61, 0);                       // R3 disabled, own still hits
    clear(4'b0011);                                   // R6 partial clear
    do_start(); addr_byte = {7'h08, 1'b0}; addr_valid = 1;
    clr_match = 4'b1111; tick(); clr_match = 0; addr_valid = 0; tick(); // R6 set wins
    clear(4'b1111);
    stretch_en = 1;
    do_start(); send(7'h08, 1);                       // R8 hold up
    do_start(); addr_byte = {7'h08, 1'b0}; addr_valid = 1; tick(3); // R11 stalled
    clear(4'b1000); tick();                           // hold drops, byte taken
    addr_valid = 0; tick(2);
    clear(4'b1111);
    stretch_en = 0;
    do_start(1); send(7'h08, 0);                      // R9 error, phase closed
    do_start(); do_stop(1); send(7'h08, 0);           // R9 stop mid byte closes
    clr_berr = 1; do_stop(1); clr_berr = 0;           // R9 set wins over clear
    clr_berr = 1; tick(); clr_berr = 0;
    do_start(); do_stop(); send(7'h08, 0);            // R10 stop closes phase
    do_start(); send(7'h55, 0);                       // R5 unknown address NAK
    for (int i = 0; i < 3000; i++) begin
      addr_valid  = ($urandom % 3) == 0;
      addr_byte   = ($urandom % 2) ? {7'h08 | 7'(($urandom % 2) << 2), 1'($urandom)} : 8'($urandom);
      if ($urandom % 4 == 0) addr_byte[7:1] = 7'b1100001;
      start_pulse = ($urandom % 5) == 0;
      stop_pulse  = ($urandom % 11) == 0;
      mid_byte    = ($urandom % 7) == 0;
      own_addr    = ($urandom % 2) ? 7'h08 : 7'h2A;
      src_en      = 4'($urandom);
      stretch_en  = ($urandom % 3) == 0;
      clr_match   = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      clr_berr    = ($urandom % 9) == 0;
      if (i == 1500) rst_n = 0;
      if (i == 1503) rst_n = 1;
      tick();
    end
    addr_valid = 0; start_pulse = 0; stop_pulse = 0; clr_match = 0;
    tick(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule